// File: doc/BRIEF.md
# Bayer-to-RGB Demosaicing Stage

This stage sits right after the sensor front end. Its input is a raster stream of 8-bit samples taken through a colour filter mosaic. Each sample comes with a valid flag, its zero-based row and column inside the frame, and a strobe that marks the end of a frame. For every interior sample the stage produces one full RGB pixel. The sample's own filter colour passes through unchanged. The two missing channels are filled in by averaging the closest neighbours that carry those colours.

Two column-addressed line buffers hold the rows above the incoming sample. A 3x3 register window then presents a complete neighbourhood one clock edge after the sample that completes it. A two-stage adder tree forms the averages, and because every average covers two or four samples the division is a shift. Samples on the outer ring of the frame serve only as neighbours, so the output raster is two rows and two columns smaller than the input. The output coordinates come from their own wrap-around counters.

Top module: `bayer_demosaic`

## Requirements
- R1: The filter colour of a centre sample comes from the parity of its input coordinates, encoded as {column odd, row odd}: 00 is green-on-red-row (G1), 01 is blue, 10 is red, 11 is green-on-blue-row (G2).
- R2: The output channel that matches the centre's filter colour equals the centre sample exactly. Both green phases drive the green output.
- R3: At G1 sites, red is the mean of the left and right neighbours and blue is the mean of the upper and lower neighbours. At G2 sites these two are swapped. At red and blue sites, green is the mean of the four orthogonal neighbours and the remaining colour is the mean of the four diagonal neighbours. Every mean discards its fraction.
- R4: No pixel is emitted for a sample in the first or last row or column. A frame of H rows and W columns yields (H-2)*(W-2) outputs.
- R5: Output coordinates are zero-based inside the cropped raster and follow raster order. The column wraps after W-3, the row advances on each wrap, and the row wraps to 0 after H-3.
- R6: An output appears on the third rising edge, counting the edge that samples the lower-right neighbour of its centre.
- R7: Sums are wide enough that an all-255 neighbourhood gives 255 on every channel.
- R8: A frame-end strobe returns the output coordinate counters to (0,0), even after a truncated frame.
- R9: While reset is low, the output valid flag and all data outputs are zero.
- R10: Cycles with the input valid flag low, whether between rows or within a row, emit nothing and leave the window contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input sample is valid |
| pix_i | input | 8 | Mosaic sample |
| row_i | input | ROW_W | Zero-based input row |
| col_i | input | COL_W | Zero-based input column |
| frame_end_i | input | 1 | End-of-frame strobe |
| rgb_valid_o | output | 1 | Output pixel valid |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| row_o | output | ROW_W | Zero-based row in the cropped raster |
| col_o | output | COL_W | Zero-based column in the cropped raster |

## Verification
Each output pixel is due on the third rising edge, counting the edge that sampled its lower-right neighbour. The bench records the cycle number of every driven sample. When an output is sampled at the following falling edge, the bench compares the current cycle against that record plus two. Coordinates and colour values are sampled at the same point and checked against a running index of expected outputs. After each frame the bench allows a settle period, then checks the output count and confirms the output has gone quiet before it issues the frame-end strobe.

// File: rtl/demosaic_pkg.sv
package demosaic_pkg;
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;
  // [row][col]; row 0 is the oldest line, col 0 the oldest column
  typedef pix_t [2:0][2:0] win_t;

  // encoding is {col odd, row odd}
  typedef enum logic [1:0] {
    PH_G1 = 2'b00,
    PH_B  = 2'b01,
    PH_R  = 2'b10,
    PH_G2 = 2'b11
  } phase_e;
endpackage

// File: rtl/demosaic_linebuf.sv
module demosaic_linebuf
  import demosaic_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  pix_t          din_i,
  output pix_t          dout_o
);
  pix_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= din_i;
  end

  // read returns the sample stored one line earlier at this column
  assign dout_o = mem_q[addr_i];
endmodule

// File: rtl/demosaic_window.sv
module demosaic_window
  import demosaic_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int ROW_W = 6,
  parameter int COL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  pix_t             pix_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             win_valid_o,
  output win_t             win_o,
  output phase_e           phase_o
);
  localparam int NLINES = 2;

  pix_t   tap [NLINES+1];
  win_t   win_q;
  logic   win_valid_q;
  phase_e phase_q;

  assign tap[0] = pix_i;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    demosaic_linebuf #(.DEPTH(IMG_W), .AW(COL_W)) u_lb (
      .clk_i (clk_i),
      .we_i  (pix_valid_i),
      .addr_i(col_i),
      .din_i (tap[i]),
      .dout_o(tap[i+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      win_valid_q <= 1'b0;
      phase_q     <= PH_G1;
    end else begin
      win_valid_q <= pix_valid_i && (row_i >= 2) && (col_i >= 2);
      if (pix_valid_i) begin
        for (int r = 0; r < 3; r++) begin
          win_q[r][0] <= win_q[r][1];
          win_q[r][1] <= win_q[r][2];
          win_q[r][2] <= tap[2-r];
        end
        // centre sits one row up and one column left of the new sample
        phase_q <= phase_e'({~col_i[0], ~row_i[0]});
      end
    end
  end

  assign win_valid_o = win_valid_q;
  assign win_o       = win_q;
  assign phase_o     = phase_q;

  a_r4_edge_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && ((row_i < 2) || (col_i < 2))) |=> !win_valid_o);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> ($stable(win_o) && !win_valid_o));
endmodule

// File: rtl/demosaic_avg.sv
module demosaic_avg
  import demosaic_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int ROW_W = 6,
  parameter int COL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  logic             win_valid_i,
  input  win_t             win_i,
  input  phase_e           phase_i,
  output logic             rgb_valid_o,
  output pix_t             red_o,
  output pix_t             green_o,
  output pix_t             blue_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  typedef logic [PIX_W:0]   sum1_t;
  typedef logic [PIX_W+1:0] sum2_t;

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 3);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 3);

  // stage 1: widened pair sums
  sum1_t  s1_h_q, s1_v_q, s1_dt_q, s1_db_q;
  pix_t   s1_c_q;
  phase_e s1_ph_q;
  logic   s1_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_h_q     <= '0;
      s1_v_q     <= '0;
      s1_dt_q    <= '0;
      s1_db_q    <= '0;
      s1_c_q     <= '0;
      s1_ph_q    <= PH_G1;
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= win_valid_i;
      if (win_valid_i) begin
        s1_h_q  <= {1'b0, win_i[1][0]} + {1'b0, win_i[1][2]};
        s1_v_q  <= {1'b0, win_i[0][1]} + {1'b0, win_i[2][1]};
        s1_dt_q <= {1'b0, win_i[0][0]} + {1'b0, win_i[0][2]};
        s1_db_q <= {1'b0, win_i[2][0]} + {1'b0, win_i[2][2]};
        s1_c_q  <= win_i[1][1];
        s1_ph_q <= phase_i;
      end
    end
  end

  // stage 2: final sums, shift-divide, phase steering
  sum2_t cross_s, diag_s;
  pix_t  avg_h, avg_v, avg_x, avg_d;
  pix_t  r_d, g_d, b_d;

  always_comb begin
    cross_s = {1'b0, s1_h_q} + {1'b0, s1_v_q};
    diag_s  = {1'b0, s1_dt_q} + {1'b0, s1_db_q};
    avg_h   = s1_h_q[PIX_W:1];
    avg_v   = s1_v_q[PIX_W:1];
    avg_x   = cross_s[PIX_W+1:2];
    avg_d   = diag_s[PIX_W+1:2];
    unique case (s1_ph_q)
      PH_G1:   begin r_d = avg_h;  g_d = s1_c_q; b_d = avg_v;  end
      PH_G2:   begin r_d = avg_v;  g_d = s1_c_q; b_d = avg_h;  end
      PH_R:    begin r_d = s1_c_q; g_d = avg_x;  b_d = avg_d;  end
      default: begin r_d = avg_d;  g_d = avg_x;  b_d = s1_c_q; end
    endcase
  end

  logic [ROW_W-1:0] cnt_row_q;
  logic [COL_W-1:0] cnt_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_valid_o <= 1'b0;
      red_o       <= '0;
      green_o     <= '0;
      blue_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      cnt_row_q   <= '0;
      cnt_col_q   <= '0;
    end else begin
      rgb_valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        red_o   <= r_d;
        green_o <= g_d;
        blue_o  <= b_d;
        row_o   <= cnt_row_q;
        col_o   <= cnt_col_q;
      end
      if (frame_end_i) begin
        cnt_row_q <= '0;
        cnt_col_q <= '0;
      end else if (s1_valid_q) begin
        if (cnt_col_q == COL_LAST) begin
          cnt_col_q <= '0;
          cnt_row_q <= (cnt_row_q == ROW_LAST) ? '0 : cnt_row_q + 1'b1;
        end else begin
          cnt_col_q <= cnt_col_q + 1'b1;
        end
      end
    end
  end

  a_r2_red_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_ph_q == PH_R) |=> (red_o == $past(s1_c_q)));

  a_r2_blue_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_ph_q == PH_B) |=> (blue_o == $past(s1_c_q)));

  a_r2_green_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && (s1_ph_q == PH_G1 || s1_ph_q == PH_G2)) |=> (green_o == $past(s1_c_q)));

  a_r5_coord_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgb_valid_o |-> (row_o <= ROW_LAST && col_o <= COL_LAST));
endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
  import demosaic_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int ROW_W = $clog2(IMG_H),
  parameter int COL_W = $clog2(IMG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [7:0]       pix_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             frame_end_i,
  output logic             rgb_valid_o,
  output logic [7:0]       red_o,
  output logic [7:0]       green_o,
  output logic [7:0]       blue_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic   win_valid;
  win_t   win;
  phase_e phase;

  demosaic_window #(.IMG_W(IMG_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_valid_i(pix_valid_i),
    .pix_i      (pix_i),
    .row_i      (row_i),
    .col_i      (col_i),
    .win_valid_o(win_valid),
    .win_o      (win),
    .phase_o    (phase)
  );

  demosaic_avg #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ROW_W(ROW_W), .COL_W(COL_W)) u_avg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_end_i(frame_end_i),
    .win_valid_i(win_valid),
    .win_i      (win),
    .phase_i    (phase),
    .rgb_valid_o(rgb_valid_o),
    .red_o      (red_o),
    .green_o    (green_o),
    .blue_o     (blue_o),
    .row_o      (row_o),
    .col_o      (col_o)
  );

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgb_valid_o |-> $past(pix_valid_i, 3));

  a_r9_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!rgb_valid_o && red_o == '0 && green_o == '0 && blue_o == '0));
endmodule

// File: tb/bayer_demosaic_tb.sv
`timescale 1ns/1ps
module bayer_demosaic_tb;
  localparam int W  = 7;
  localparam int H  = 6;
  localparam int RW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic [7:0]    pix = '0;
  logic [RW-1:0] row = '0;
  logic [CW-1:0] col = '0;
  logic          frame_end = 1'b0;
  logic          rgb_valid;
  logic [7:0]    red, green, blue;
  logic [RW-1:0] row_out;
  logic [CW-1:0] col_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int k      = 0;
  int ftype  = 0;
  bit done   = 1'b0;
  int in_cyc [H][W];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bayer_demosaic #(.IMG_W(W), .IMG_H(H), .ROW_W(RW), .COL_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .pix_i(pix),
    .row_i(row), .col_i(col), .frame_end_i(frame_end),
    .rgb_valid_o(rgb_valid), .red_o(red), .green_o(green), .blue_o(blue),
    .row_o(row_out), .col_o(col_out)
  );

  function automatic int pixval(int ft, int r, int c);
    case (ft)
      0: return (r*37 + c*11 + r*c*5 + 3) % 256;
      1: return 255;
      2: case ({c[0], r[0]})
           2'b00: return 10;
           2'b01: return 90;
           2'b10: return 200;
           default: return 50;
         endcase
      default: return (r*c*29 + c*7 + r*101 + 17) % 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && rgb_valid && !done) begin
      int er, ec, rr, cc, pc, h, v, x, d, er_r, er_g, er_b;
      er = k / (W-2);
      ec = k % (W-2);
      if (k >= (H-2)*(W-2)) check("R4 extra output", k, (H-2)*(W-2)-1);
      if (k == 0) begin
        check("R8 first row", int'(row_out), 0);
        check("R8 first col", int'(col_out), 0);
      end
      check("R5 row", int'(row_out), er);
      check("R5 col", int'(col_out), ec);
      rr = er + 1;
      cc = ec + 1;
      pc = pixval(ftype, rr, cc);
      h = (pixval(ftype, rr, cc-1) + pixval(ftype, rr, cc+1)) / 2;
      v = (pixval(ftype, rr-1, cc) + pixval(ftype, rr+1, cc)) / 2;
      x = (pixval(ftype, rr, cc-1) + pixval(ftype, rr, cc+1)
         + pixval(ftype, rr-1, cc) + pixval(ftype, rr+1, cc)) / 4;
      d = (pixval(ftype, rr-1, cc-1) + pixval(ftype, rr-1, cc+1)
         + pixval(ftype, rr+1, cc-1) + pixval(ftype, rr+1, cc+1)) / 4;
      case ({cc[0], rr[0]})
        2'b00: begin er_r = h; er_g = pc; er_b = v; end
        2'b11: begin er_r = v; er_g = pc; er_b = h; end
        2'b10: begin er_r = pc; er_g = x; er_b = d; end
        default: begin er_r = d; er_g = x; er_b = pc; end
      endcase
      case ({cc[0], rr[0]})
        2'b10: begin check("R2 red own", int'(red), er_r);
                     check("R3 green", int'(green), er_g);
                     check("R3 blue", int'(blue), er_b); end
        2'b01: begin check("R2 blue own", int'(blue), er_b);
                     check("R3 red", int'(red), er_r);
                     check("R3 green", int'(green), er_g); end
        default: begin check("R2 green own", int'(green), er_g);
                       check("R3 red", int'(red), er_r);
                       check("R3 blue", int'(blue), er_b); end
      endcase
      if (ftype == 2) begin
        case ({cc[0], rr[0]})
          2'b10: check("R1 red site", int'(red), 200);
          2'b01: check("R1 blue site", int'(blue), 90);
          2'b00: check("R1 G1 site", int'(green), 10);
          default: check("R1 G2 site", int'(green), 50);
        endcase
      end
      if (ftype == 1) begin
        check("R7 red sat", int'(red), 255);
        check("R7 green sat", int'(green), 255);
        check("R7 blue sat", int'(blue), 255);
      end
      if (rr+1 < H && cc+1 < W) check("R6 latency", cyc, in_cyc[rr+1][cc+1] + 2);
      k++;
    end
  end

  task automatic drive_frame(input int ft, input int nrows, input int gap, input bit stall);
    int exp_n;
    ftype = ft;
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < W; c++) begin
        if (stall && c == 3) begin
          @(negedge clk);
          pix_valid = 1'b0;
          pix = 8'hA5;
        end
        @(negedge clk);
        pix_valid = 1'b1;
        pix = 8'(pixval(ft, r, c));
        row = RW'(r);
        col = CW'(c);
        in_cyc[r][c] = cyc + 1;
      end
      if (gap > 0) begin
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (5) @(negedge clk);
    exp_n = (nrows >= 3) ? (nrows-2)*(W-2) : 0;
    check("R4 output count", k, exp_n);
    check("R10 quiet when idle", int'(rgb_valid), 0);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    k = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid in reset", int'(rgb_valid), 0);
    check("R9 red in reset", int'(red), 0);
    check("R9 green in reset", int'(green), 0);
    check("R9 blue in reset", int'(blue), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    drive_frame(0, 3, 0, 1'b0);   // truncated frame, then restart (R8)
    drive_frame(0, H, 2, 1'b0);
    drive_frame(2, H, 0, 1'b0);
    drive_frame(1, H, 3, 1'b0);
    drive_frame(3, H, 0, 1'b1);   // stalls inside rows (R10)
    drive_frame(0, H, 1, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule